// File: doc/BRIEF.md
# Three-Input Divided Clock Selector

This block is one clock-output slice. It has three source clocks and a private divider for each of them. A two-bit select value chooses which divided source reaches the output, and one further select code parks the output in a switched-off state. All logic runs on a single fast reference clock. Each source clock is presented as a one-cycle enable strobe on that reference clock, and the output is produced the same way, as a train of single-cycle pulses. A downstream block would gate or count with these pulses.

A select write always stops the output before the new source takes over. The new source must then deliver two complete divided periods before the output resumes. At that moment a per-source running flag rises, so software can poll it to confirm that the switch has finished. The select value and the three divider values live in a small register file, and the addressed register can be read back combinationally.

Top module: `clksel3_slice`

## Requirements
- R1: After reset the select register reads 3 (off), all three divider registers read 0, every running flag is low and the output pulse is low.
- R2: With divider value N on the selected source, the slice emits one output pulse for every N+1 strobes of that source. Each divider counts strobes from 0 and wraps after its N+1-th strobe. The output pulse appears in the cycle after the strobe that completes a period.
- R3: While a source drives the output, strobes on the other two sources produce no output pulse.
- R4: A select write with code 0, 1 or 2 drops all running flags and holds the output low from the next cycle. The running flag of the chosen source rises in the cycle after the second completed divided period of that source. Output pulses resume only with the period after that one.
- R5: A select write with code 3 switches the output off. The output and all running flags then stay low until the next legal source selection.
- R6: A select write of any value from 4 to 31 is ignored. The select register, the running flags and the output all continue unchanged.
- R7: At most one running flag is high at a time, and an output pulse only occurs while one is high.
- R8: Register map, where the address is cfg_addr: address 0 holds the select in bits [1:0] and reads 0 in bits [4:2]. Addresses 1, 2 and 3 hold the 5-bit divider of sources 0, 1 and 2. cfg_rdata shows the addressed register combinationally.
- R9: Writing the source that is already running starts a full new switch: the running flag drops and then rises again after two divided periods.
- R10: A divider write restarts that source's count from 0 but does not disturb the switch state or the running flags.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_tick | input | 3 | Enable strobe of each source clock |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register address for write and read |
| cfg_wdata | input | 5 | Register write data |
| cfg_rdata | output | 5 | Contents of the addressed register |
| out_pulse | output | 1 | Output clock as a single-cycle pulse train |
| running | output | 3 | Per-source running flags |

## Verification
The hardest case to reach is a select rewrite that lands in the same cycle as a completed period of the old source, or partway through the two-period settle. A pulse could then leak out, or the settle count could carry over from the earlier switch. Reaching it needs dense strobes on every source together with writes whose timing is not aligned to any divider phase. The random phase therefore keeps all three strobes toggling and issues occasional writes at random cycles, including illegal select codes and divider writes. The directed part rewrites the running source and switches off mid-stream.

// File: rtl/clksel3_pkg.sv
package clksel3_pkg;

  typedef enum logic [1:0] {
    SW_OFF    = 2'd0,
    SW_SETTLE = 2'd1,
    SW_RUN    = 2'd2
  } sw_state_e;

  // A select code is accepted when it names a source or the off code.
  function automatic logic code_is_legal(int unsigned code, int unsigned n_src);
    return code <= n_src;
  endfunction

  // A divided period completes when the count has reached the divider value.
  function automatic logic div_wraps(int unsigned count, int unsigned limit);
    return count >= limit;
  endfunction

endpackage

// File: rtl/clksel3_divider.sv
module clksel3_divider
  import clksel3_pkg::*;
#(
  parameter int DIV_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             src_tick,
  input  logic             restart,
  input  logic [DIV_W-1:0] div_val,
  output logic             div_tick
);

  logic [DIV_W-1:0] cnt_q;

  assign div_tick = src_tick && div_wraps(32'(cnt_q), 32'(div_val));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (restart) begin
      cnt_q <= '0;
    end else if (src_tick) begin
      if (div_tick) cnt_q <= '0;
      else          cnt_q <= cnt_q + DIV_W'(1);
    end
  end

endmodule

// File: rtl/clksel3_regs.sv
module clksel3_regs
  import clksel3_pkg::*;
#(
  parameter int NUM_SRC = 3,
  parameter int DIV_W   = 5,
  parameter int SEL_W   = 2,
  parameter int ADDR_W  = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cfg_we,
  input  logic [ADDR_W-1:0]        cfg_addr,
  input  logic [DIV_W-1:0]         cfg_wdata,
  output logic [SEL_W-1:0]         sel_q,
  output logic [NUM_SRC*DIV_W-1:0] div_flat,
  output logic                     sel_wr,
  output logic [NUM_SRC-1:0]       div_wr,
  output logic [DIV_W-1:0]         cfg_rdata
);

  localparam logic [SEL_W-1:0] OFF_CODE = SEL_W'(NUM_SRC);

  assign sel_wr = cfg_we && (cfg_addr == '0) &&
                  code_is_legal(32'(cfg_wdata), NUM_SRC);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sel_q <= OFF_CODE;
    else if (sel_wr) sel_q <= cfg_wdata[SEL_W-1:0];
  end

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_divreg
    assign div_wr[g] = cfg_we && (cfg_addr == ADDR_W'(g + 1));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         div_flat[g*DIV_W +: DIV_W] <= '0;
      else if (div_wr[g]) div_flat[g*DIV_W +: DIV_W] <= cfg_wdata;
    end
  end

  always_comb begin
    cfg_rdata = '0;
    if (cfg_addr == '0) cfg_rdata[SEL_W-1:0] = sel_q;
    for (int k = 0; k < NUM_SRC; k++) begin
      if (cfg_addr == ADDR_W'(k + 1)) cfg_rdata = div_flat[k*DIV_W +: DIV_W];
    end
  end

endmodule

// File: rtl/clksel3_switch.sv
module clksel3_switch
  import clksel3_pkg::*;
#(
  parameter int NUM_SRC      = 3,
  parameter int SEL_W        = 2,
  parameter int SETTLE_TICKS = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sel_wr,
  input  logic [SEL_W-1:0]   new_code,
  input  logic [NUM_SRC-1:0] div_tick,
  output logic               out_pulse,
  output logic [NUM_SRC-1:0] running,
  output logic               switch_start,
  output logic               settle_done
);

  localparam logic [SEL_W-1:0] OFF_CODE = SEL_W'(NUM_SRC);
  localparam int PAD_W    = 1 << SEL_W;
  localparam int SETTLE_W = $clog2(SETTLE_TICKS + 1);

  sw_state_e         state_q;
  logic [SEL_W-1:0]  act_q;
  logic [SETTLE_W-1:0] seen_q;
  logic [PAD_W-1:0]  tick_pad;
  logic              act_tick;
  logic              go_off;

  assign tick_pad     = PAD_W'(div_tick);
  assign act_tick     = tick_pad[act_q];
  assign go_off       = sel_wr && (new_code == OFF_CODE);
  assign switch_start = sel_wr && (new_code != OFF_CODE);
  assign settle_done  = (state_q == SW_SETTLE) && act_tick &&
                        (seen_q == SETTLE_W'(SETTLE_TICKS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= SW_OFF;
      act_q     <= '0;
      seen_q    <= '0;
      running   <= '0;
      out_pulse <= 1'b0;
    end else begin
      out_pulse <= !sel_wr && (state_q == SW_RUN) && act_tick;
      if (go_off) begin
        state_q <= SW_OFF;
        seen_q  <= '0;
        running <= '0;
      end else if (switch_start) begin
        state_q <= SW_SETTLE;
        act_q   <= new_code;
        seen_q  <= '0;
        running <= '0;
      end else if (settle_done) begin
        state_q <= SW_RUN;
        seen_q  <= '0;
        running <= NUM_SRC'(1) << act_q;
      end else if ((state_q == SW_SETTLE) && act_tick) begin
        seen_q  <= seen_q + SETTLE_W'(1);
      end
    end
  end

endmodule

// File: rtl/clksel3_slice.sv
module clksel3_slice
  import clksel3_pkg::*;
#(
  parameter int NUM_SRC      = 3,
  parameter int DIV_W        = 5,
  parameter int SETTLE_TICKS = 2,
  parameter int SEL_W        = $clog2(NUM_SRC + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_tick,
  input  logic               cfg_we,
  input  logic [SEL_W-1:0]   cfg_addr,
  input  logic [DIV_W-1:0]   cfg_wdata,
  output logic [DIV_W-1:0]   cfg_rdata,
  output logic               out_pulse,
  output logic [NUM_SRC-1:0] running
);

  logic [SEL_W-1:0]         sel_q;
  logic [NUM_SRC*DIV_W-1:0] div_flat;
  logic                     sel_wr;
  logic [NUM_SRC-1:0]       div_wr;
  logic [NUM_SRC-1:0]       div_tick;
  logic                     switch_start;
  logic                     settle_done;

  clksel3_regs #(
    .NUM_SRC(NUM_SRC), .DIV_W(DIV_W), .SEL_W(SEL_W), .ADDR_W(SEL_W)
  ) i_regs (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .sel_q(sel_q), .div_flat(div_flat),
    .sel_wr(sel_wr), .div_wr(div_wr), .cfg_rdata(cfg_rdata)
  );

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_div
    clksel3_divider #(.DIV_W(DIV_W)) i_div (
      .clk(clk), .rst_n(rst_n), .src_tick(src_tick[g]), .restart(div_wr[g]),
      .div_val(div_flat[g*DIV_W +: DIV_W]), .div_tick(div_tick[g])
    );
  end

  clksel3_switch #(
    .NUM_SRC(NUM_SRC), .SEL_W(SEL_W), .SETTLE_TICKS(SETTLE_TICKS)
  ) i_switch (
    .clk(clk), .rst_n(rst_n), .sel_wr(sel_wr), .new_code(cfg_wdata[SEL_W-1:0]),
    .div_tick(div_tick), .out_pulse(out_pulse), .running(running),
    .switch_start(switch_start), .settle_done(settle_done)
  );

endmodule

// File: rtl/clksel3_chk.sv
module clksel3_chk #(
  parameter int NUM_SRC = 3,
  parameter int DIV_W   = 5,
  parameter int SEL_W   = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cfg_we,
  input logic [SEL_W-1:0]   cfg_addr,
  input logic [DIV_W-1:0]   cfg_wdata,
  input logic               out_pulse,
  input logic [NUM_SRC-1:0] running,
  input logic [SEL_W-1:0]   sel_q,
  input logic               switch_start,
  input logic               settle_done
);

  // R7
  running_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(running));

  // R7
  out_needs_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_pulse |-> (running != '0));

  // R4
  switch_mutes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    switch_start |=> (!out_pulse && running == '0));

  // R4
  run_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(|running) |-> $past(settle_done));

  // R5
  off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_addr == '0 && cfg_wdata == DIV_W'(NUM_SRC))
      |=> (running == '0 && !out_pulse));

  // R6
  illegal_sel_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_addr == '0 && cfg_wdata > DIV_W'(NUM_SRC))
      |=> (sel_q == $past(sel_q)));

endmodule

bind clksel3_slice clksel3_chk #(
  .NUM_SRC(NUM_SRC), .DIV_W(DIV_W), .SEL_W(SEL_W)
) i_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
  .cfg_wdata(cfg_wdata), .out_pulse(out_pulse), .running(running),
  .sel_q(sel_q), .switch_start(switch_start), .settle_done(settle_done)
);

// File: tb/test_clksel3_slice.sv
module test_clksel3_slice;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] src_tick = '0;
  logic       cfg_we = 1'b0;
  logic [1:0] cfg_addr = '0;
  logic [4:0] cfg_wdata = '0;
  logic [4:0] cfg_rdata;
  logic       out_pulse;
  logic [2:0] running;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // reference model state
  int m_cnt[3];
  int m_div[3];
  int m_sel;
  int m_state;   // 0 off, 1 settling, 2 running
  int m_act;
  int m_seen;
  int m_run;
  int m_out;

  always #2 clk = ~clk;

  clksel3_slice i_clksel3_slice (
    .clk(clk), .rst_n(rst_n), .src_tick(src_tick), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .out_pulse(out_pulse), .running(running)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // a period of source i completes on a strobe when the count equals N
  function automatic bit period_done(int i, bit s);
    return s && (m_cnt[i] == m_div[i]);
  endfunction

  function automatic int reg_value(int a);
    if (a == 0) return m_sel;
    return m_div[a-1];
  endfunction

  // Called at a falling edge: compare, drive, advance model, next falling edge.
  task automatic step(input logic [2:0] s, input bit we, input int addr, input int wd);
    bit fire[3];
    bit legal_sel;
    chk("R2 out_pulse", int'(out_pulse), m_out);
    chk("R4 running", int'(running), m_run);
    chk("R7 single running flag", int'($countones(running) <= 1), 1);
    src_tick  = s;
    cfg_we    = we;
    cfg_addr  = addr[1:0];
    cfg_wdata = wd[4:0];
    for (int i = 0; i < 3; i++) fire[i] = period_done(i, s[i]);
    legal_sel = we && addr == 0 && wd <= 3;
    m_out = (!legal_sel && m_state == 2 && fire[m_act]) ? 1 : 0;
    if (legal_sel) begin
      m_sel = wd;
      m_run = 0;
      m_seen = 0;
      if (wd == 3) m_state = 0;
      else begin m_state = 1; m_act = wd; end
    end else if (m_state == 1 && fire[m_act]) begin
      if (m_seen == 1) begin
        m_state = 2; m_run = 1 << m_act; m_seen = 0;
      end else m_seen = m_seen + 1;
    end
    for (int i = 0; i < 3; i++) begin
      if (we && addr == i + 1) begin
        m_div[i] = wd; m_cnt[i] = 0;
      end else if (s[i]) begin
        m_cnt[i] = fire[i] ? 0 : m_cnt[i] + 1;
      end
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(int addr, int wd);
    step(3'b000, 1'b1, addr, wd);
  endtask

  task automatic rd_chk(int addr, string tag);
    cfg_we = 1'b0;
    cfg_addr = addr[1:0];
    #1;
    chk(tag, int'(cfg_rdata), reg_value(addr));
  endtask

  task automatic settle_on(int src);
    for (int n = 0; n < 400 && m_run == 0; n++) step(3'(1 << src), 1'b0, 0, 0);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : main
    int pulses;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 3; i++) begin m_cnt[i] = 0; m_div[i] = 0; end
    m_sel = 3; m_state = 0; m_act = 0; m_seen = 0; m_run = 0; m_out = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk("R1 out_pulse", int'(out_pulse), 0);
    chk("R1 running", int'(running), 0);
    for (int a = 0; a < 4; a++) rd_chk(a, "R1 reset register");

    // R8 register map
    wr(1, 7); wr(2, 2); wr(3, 31);
    for (int a = 1; a < 4; a++) rd_chk(a, "R8 divider readback");
    wr(1, 0); wr(2, 0); wr(3, 0);

    // R4 first switch to source 0, divider 2 (divide by 3)
    wr(1, 2);
    wr(0, 0);
    rd_chk(0, "R8 select readback");
    chk("R4 running low after write", int'(running), 0);
    settle_on(0);
    chk("R4 running source 0", int'(running), 1);

    // R2 count output pulses over 30 strobes of divide-by-3
    pulses = 0;
    for (int n = 0; n < 30; n++) begin
      step(3'b001, 1'b0, 0, 0);
      pulses += int'(out_pulse);
    end
    chk("R2 pulses per 30 strobes", pulses, 10);

    // R3 other sources strobing, selected one silent
    step(3'b000, 1'b0, 0, 0);
    pulses = 0;
    for (int n = 0; n < 20; n++) begin
      step(3'b110, 1'b0, 0, 0);
      pulses += int'(out_pulse);
    end
    chk("R3 no pulses from unselected sources", pulses, 0);

    // R10 divider write keeps running state
    wr(1, 0);
    chk("R10 running kept after divider write", int'(running), 1);

    // R9 rewrite of the running source
    wr(0, 0);
    chk("R9 running drops on rewrite", int'(running), 0);
    settle_on(0);
    chk("R9 running reasserts", int'(running), 1);

    // R5 off code
    wr(0, 3);
    pulses = 0;
    for (int n = 0; n < 20; n++) begin
      step(3'b111, 1'b0, 0, 0);
      pulses += int'(out_pulse);
      chk("R5 running while off", int'(running), 0);
    end
    chk("R5 no pulses while off", pulses, 0);
    rd_chk(0, "R5 select reads off code");

    // R6 illegal select codes
    wr(0, 1);
    settle_on(1);
    wr(0, 5);
    rd_chk(0, "R6 select unchanged");
    chk("R6 running unchanged", int'(running), 2);
    wr(0, 31);
    rd_chk(0, "R6 select unchanged high code");
    step(3'b010, 1'b0, 0, 0);
    chk("R6 still running", int'(running), 2);

    // random phase
    for (int n = 0; n < 20000; n++) begin
      logic [2:0] s;
      bit we;
      int addr, wd;
      s = 3'($urandom);
      we = ($urandom % 24) == 0;
      addr = $urandom % 4;
      wd = (addr == 0) ? (($urandom % 8 == 0) ? $urandom % 32 : $urandom % 4)
                       : $urandom % 6;
      step(s, we, addr, wd);
    end
    for (int a = 0; a < 4; a++) rd_chk(a, "R8 final readback");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule